// File: doc/BRIEF.md
# Development-Mode Reset Suppression Controller

This block sits between a supervisor's fault detectors and its reset and fail-safe outputs. It keeps a sticky development-mode flag that software or a test strap can set once per power cycle. While the flag is set, the block stops selected watchdog and timing faults from resetting the system. A suppressed watchdog failure still writes its cause into the reset-source field and raises an interrupt, so debug software can see the problem without losing control of the system.

The flag is driven by a four-state machine. After power-on reset the machine is in SAMPLE. On the next edge it goes to ACTIVE if the strap is high, and to ARMABLE if the strap is low. From ARMABLE, a special-mode write with the enable bit set while the operating mode is Start-up moves it to ACTIVE. From ACTIVE, a mode-register write with the development bit clear moves it to SPENT. SPENT is left only through power-on reset.

Reset pulses come from a second machine with two states. IDLE goes to HOLD on a reset trigger. HOLD goes back to IDLE when its length counter runs out. A new trigger while in HOLD reloads the counter. The fault sources themselves are out of scope: watchdog timers, comparators and analog circuits sit outside this block.

Top module: `dbgrst_guard`

## Requirements
- R1: While and after power-on reset (`por_n` low, active-low asynchronous), the outputs are `rst_req_o`=0, `failsafe_req_o`=0, `irq_req_o`=0 and `rst_src_o`=0 (the power-on code).
- R2: The strap input is sampled on the first clock edge after `por_n` rises. A high strap turns development mode on. The strap has no effect at any later time.
- R3: A special-mode write (`spec_wr_i`) with `spec_dev_i`=1 turns development mode on only if both of these hold:
  - the operating mode is Start-up (`opmode_i`=0);
  - the mode was never active since power-on.
  A write in any other operating mode is ignored.
- R4: While development mode is active, a mode write (`mode_wr_i`) with `mode_dev_i`=1 keeps it active. A mode write with `mode_dev_i`=0 ends it from the next cycle on, whichever path turned it on.
- R5: After development mode ends, neither the strap nor a special-mode write turns it on again until a new power-on reset.
- R6: While development mode is active, the following faults do not assert `rst_req_o`: watchdog overflow (outside Standby=3 and Sleep=4), window miss, interrupt time-out and start-up expiry. While it is inactive, each of these starts a reset pulse in the cycle after the fault.
- R7: A suppressed watchdog overflow (code 1) or window miss (code 2) still loads `rst_src_o`. It also gives a one-cycle `irq_req_o` pulse in the cycle after the fault. A suppressed interrupt time-out (code 3) or start-up expiry (code 4) changes nothing.
- R8: `fs_cause_i` gives a one-cycle `failsafe_req_o` pulse only while development mode is inactive. A long main-supply undervoltage (`uv_clamp_i`) always gives the pulse and logs code 7.
- R9: A short main-supply undervoltage (`v1_low_i`, the Start-up-to-Restart path) always gives a reset pulse and logs code 5.
- R10: A watchdog overflow in Standby (3) or Sleep (4) always gives a reset pulse and logs code 6, whatever the flag state.
- R11: When several faults arrive in the same cycle, `rst_src_o` takes the first loggable cause in this priority order: 7, 5, 6, 1, 2, 3, 4. Codes 3 and 4 are loggable only while development mode is inactive. `rst_src_o` is registered on the same edge as the reset pulse starts.
- R12: A reset pulse lasts exactly `RST_LEN` cycles (default 2, at least 2). A new trigger during a pulse restarts the full length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| strap_i | input | 1 | Test strap, sampled once after power-on |
| opmode_i | input | 3 | Operating mode: 0 Start-up, 1 Restart, 2 Normal, 3 Standby, 4 Sleep, 5 Fail-safe |
| mode_wr_i | input | 1 | Mode-register write strobe |
| mode_dev_i | input | 1 | Development bit carried by the mode write |
| spec_wr_i | input | 1 | Special-mode register write strobe |
| spec_dev_i | input | 1 | Initial-enable bit carried by the special-mode write |
| wd_ovf_i | input | 1 | Watchdog overflow pulse |
| wd_win_i | input | 1 | Watchdog window-miss pulse |
| int_to_i | input | 1 | Interrupt time-out pulse |
| start_to_i | input | 1 | Start-up time expiry pulse |
| v1_low_i | input | 1 | Short main-supply undervoltage pulse |
| uv_clamp_i | input | 1 | Undervoltage longer than the clamp time |
| fs_cause_i | input | 1 | Other fail-safe cause |
| rst_req_o | output | 1 | Registered system reset request |
| failsafe_req_o | output | 1 | Registered fail-safe request pulse |
| irq_req_o | output | 1 | Interrupt pulse for a suppressed watchdog fault |
| rst_src_o | output | 3 | Last logged reset cause code |

## Verification
The assertions assume that `opmode_i` holds one of the six defined codes. They also assume that fault inputs are synchronous pulses that are stable across the sampling edge. Write strobes are taken as one-cycle events.

The stimulus changes every input only on the falling clock edge. It sets `opmode_i` only to defined codes. It raises fault and write strobes for exactly one cycle, and it drops all of them back to zero afterwards. Development mode has no port of its own, so its state is observed through how the block reacts to a window-miss pulse: an interrupt means the mode is on, a reset means it is off.

// File: rtl/dbgrst_pkg.sv
package dbgrst_pkg;

    typedef enum logic [2:0] {
        OPM_STARTUP  = 3'd0,
        OPM_RESTART  = 3'd1,
        OPM_NORMAL   = 3'd2,
        OPM_STANDBY  = 3'd3,
        OPM_SLEEP    = 3'd4,
        OPM_FAILSAFE = 3'd5
    } opmode_t;

    typedef enum logic [2:0] {
        CS_POWERON  = 3'd0,
        CS_WD_OVF   = 3'd1,
        CS_WD_WIN   = 3'd2,
        CS_INT_TO   = 3'd3,
        CS_START_TO = 3'd4,
        CS_V1_LOW   = 3'd5,
        CS_LP_WD    = 3'd6,
        CS_UV_CLAMP = 3'd7
    } cause_t;

    typedef enum logic [1:0] {
        DV_SAMPLE  = 2'd0,
        DV_ARMABLE = 2'd1,
        DV_ACTIVE  = 2'd2,
        DV_SPENT   = 2'd3
    } devst_t;

    typedef enum logic {
        PS_IDLE = 1'b0,
        PS_HOLD = 1'b1
    } pulse_st_t;

    function automatic logic is_low_power(input logic [2:0] m);
        return (m == OPM_STANDBY) || (m == OPM_SLEEP);
    endfunction

endpackage

// File: rtl/devflag_fsm.sv
module devflag_fsm
    import dbgrst_pkg::*;
(
    input  logic       clk,
    input  logic       por_n,
    input  logic       strap_i,
    input  logic [2:0] opmode_i,
    input  logic       spec_wr_i,
    input  logic       spec_dev_i,
    input  logic       mode_wr_i,
    input  logic       mode_dev_i,
    output logic       dev_active_o
);

    devst_t state_q, state_d;
    logic   arm_req;
    logic   drop_req;

    assign arm_req  = spec_wr_i && spec_dev_i && (opmode_i == OPM_STARTUP);
    assign drop_req = mode_wr_i && !mode_dev_i;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DV_SAMPLE:  state_d = strap_i ? DV_ACTIVE : DV_ARMABLE;
            DV_ARMABLE: if (arm_req) state_d = DV_ACTIVE;
            DV_ACTIVE:  if (drop_req) state_d = DV_SPENT;
            DV_SPENT:   state_d = DV_SPENT;
            default:    state_d = DV_SPENT;
        endcase
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) state_q <= DV_SAMPLE;
        else        state_q <= state_d;
    end

    always_comb begin
        dev_active_o = (state_q == DV_ACTIVE);
    end

    // R5: a spent flag never revives before power-on reset
    a_r5_spent_sticky: assert property (@(posedge clk) disable iff (!por_n)
        (state_q == DV_SPENT) |=> (state_q == DV_SPENT));

    // R4: a mode write with the bit clear ends the active flag
    a_r4_exit_on_clear: assert property (@(posedge clk) disable iff (!por_n)
        (state_q == DV_ACTIVE && mode_wr_i && !mode_dev_i) |=> (state_q == DV_SPENT));

    // R3: arming needs a special write with the bit set in Start-up
    a_r3_arm_only_startup: assert property (@(posedge clk) disable iff (!por_n)
        (state_q == DV_ARMABLE && !(spec_wr_i && spec_dev_i && opmode_i == OPM_STARTUP))
        |=> (state_q == DV_ARMABLE));

    // R2: the strap only matters on the edge right after power-on
    a_r2_strap_once: assert property (@(posedge clk) disable iff (!por_n)
        (state_q != DV_SAMPLE) |=> (state_q != DV_SAMPLE));

endmodule

// File: rtl/fault_router.sv
module fault_router
    import dbgrst_pkg::*;
(
    input  logic       dev_active_i,
    input  logic [2:0] opmode_i,
    input  logic       wd_ovf_i,
    input  logic       wd_win_i,
    input  logic       int_to_i,
    input  logic       start_to_i,
    input  logic       v1_low_i,
    input  logic       uv_clamp_i,
    input  logic       fs_cause_i,
    output logic       rst_trig_o,
    output logic       log_vld_o,
    output logic [2:0] log_code_o,
    output logic       irq_hit_o,
    output logic       fs_hit_o
);

    logic lp;
    logic ovf_run;
    logic ovf_lp;
    logic soft_fault;

    always_comb begin
        lp         = is_low_power(opmode_i);
        ovf_run    = wd_ovf_i && !lp;
        ovf_lp     = wd_ovf_i && lp;
        soft_fault = ovf_run || wd_win_i || int_to_i || start_to_i;

        rst_trig_o = v1_low_i || ovf_lp || (!dev_active_i && soft_fault);
        irq_hit_o  = dev_active_i && (ovf_run || wd_win_i);
        fs_hit_o   = uv_clamp_i || (fs_cause_i && !dev_active_i);

        log_vld_o  = 1'b1;
        if (uv_clamp_i)                        log_code_o = CS_UV_CLAMP;
        else if (v1_low_i)                     log_code_o = CS_V1_LOW;
        else if (ovf_lp)                       log_code_o = CS_LP_WD;
        else if (ovf_run)                      log_code_o = CS_WD_OVF;
        else if (wd_win_i)                     log_code_o = CS_WD_WIN;
        else if (int_to_i && !dev_active_i)    log_code_o = CS_INT_TO;
        else if (start_to_i && !dev_active_i)  log_code_o = CS_START_TO;
        else begin
            log_vld_o  = 1'b0;
            log_code_o = CS_POWERON;
        end
    end

endmodule

// File: rtl/reset_stretch.sv
module reset_stretch
    import dbgrst_pkg::*;
#(
    parameter int RST_LEN = 2
) (
    input  logic clk,
    input  logic por_n,
    input  logic trig_i,
    output logic rst_o
);

    localparam int CW = (RST_LEN > 2) ? $clog2(RST_LEN) : 1;
    localparam logic [CW-1:0] LOAD = CW'(RST_LEN - 1);

    pulse_st_t       st_q, st_d;
    logic [CW-1:0]   cnt_q, cnt_d;

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            PS_IDLE: begin
                if (trig_i) begin
                    st_d  = PS_HOLD;
                    cnt_d = LOAD;
                end
            end
            PS_HOLD: begin
                if (trig_i) begin
                    cnt_d = LOAD;
                end else if (cnt_q != '0) begin
                    cnt_d = cnt_q - 1'b1;
                end else begin
                    st_d = PS_IDLE;
                end
            end
            default: st_d = PS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            st_q  <= PS_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) rst_o <= 1'b0;
        else        rst_o <= trig_i || (st_q == PS_HOLD && cnt_q != '0);
    end

    // R12: a reset pulse is never shorter than two cycles
    a_r12_min_width: assert property (@(posedge clk) disable iff (!por_n)
        $rose(rst_o) |=> rst_o);

    // R12: a trigger always leaves the request high on the next cycle
    a_r12_trigger_hits: assert property (@(posedge clk) disable iff (!por_n)
        trig_i |=> rst_o);

endmodule

// File: rtl/dbgrst_guard.sv
module dbgrst_guard
    import dbgrst_pkg::*;
#(
    parameter int RST_LEN = 2
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       strap_i,
    input  logic [2:0] opmode_i,
    input  logic       mode_wr_i,
    input  logic       mode_dev_i,
    input  logic       spec_wr_i,
    input  logic       spec_dev_i,
    input  logic       wd_ovf_i,
    input  logic       wd_win_i,
    input  logic       int_to_i,
    input  logic       start_to_i,
    input  logic       v1_low_i,
    input  logic       uv_clamp_i,
    input  logic       fs_cause_i,
    output logic       rst_req_o,
    output logic       failsafe_req_o,
    output logic       irq_req_o,
    output logic [2:0] rst_src_o
);

    generate
        if (RST_LEN < 2) begin : g_len_bad
            initial $error("RST_LEN must be at least 2");
        end
    endgenerate

    logic       dev_active;
    logic       rst_trig;
    logic       log_vld;
    logic [2:0] log_code;
    logic       irq_hit;
    logic       fs_hit;

    devflag_fsm u_flag (
        .clk          (clk),
        .por_n        (por_n),
        .strap_i      (strap_i),
        .opmode_i     (opmode_i),
        .spec_wr_i    (spec_wr_i),
        .spec_dev_i   (spec_dev_i),
        .mode_wr_i    (mode_wr_i),
        .mode_dev_i   (mode_dev_i),
        .dev_active_o (dev_active)
    );

    fault_router u_route (
        .dev_active_i (dev_active),
        .opmode_i     (opmode_i),
        .wd_ovf_i     (wd_ovf_i),
        .wd_win_i     (wd_win_i),
        .int_to_i     (int_to_i),
        .start_to_i   (start_to_i),
        .v1_low_i     (v1_low_i),
        .uv_clamp_i   (uv_clamp_i),
        .fs_cause_i   (fs_cause_i),
        .rst_trig_o   (rst_trig),
        .log_vld_o    (log_vld),
        .log_code_o   (log_code),
        .irq_hit_o    (irq_hit),
        .fs_hit_o     (fs_hit)
    );

    reset_stretch #(.RST_LEN(RST_LEN)) u_pulse (
        .clk    (clk),
        .por_n  (por_n),
        .trig_i (rst_trig),
        .rst_o  (rst_req_o)
    );

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            rst_src_o      <= CS_POWERON;
            irq_req_o      <= 1'b0;
            failsafe_req_o <= 1'b0;
        end else begin
            if (log_vld) rst_src_o <= log_code;
            irq_req_o      <= irq_hit;
            failsafe_req_o <= fs_hit;
        end
    end

    // R8: a long undervoltage always reaches fail-safe
    a_r8_uv_failsafe: assert property (@(posedge clk) disable iff (!por_n)
        uv_clamp_i |=> (failsafe_req_o && rst_src_o == CS_UV_CLAMP));

    // R9: the restart path is never suppressed
    a_r9_v1_resets: assert property (@(posedge clk) disable iff (!por_n)
        v1_low_i |=> rst_req_o);

    // R10: low-power watchdog overflow always resets
    a_r10_lp_wd_resets: assert property (@(posedge clk) disable iff (!por_n)
        (wd_ovf_i && is_low_power(opmode_i)) |=> rst_req_o);

    // R6: with the flag on and no unsuppressable cause, an idle reset stays idle
    a_r6_suppress: assert property (@(posedge clk) disable iff (!por_n)
        (dev_active && !v1_low_i && !(wd_ovf_i && is_low_power(opmode_i)) && !rst_req_o)
        |=> !rst_req_o);

    // R7: a suppressed window miss still logs a nonzero cause
    a_r7_logs_cause: assert property (@(posedge clk) disable iff (!por_n)
        (dev_active && wd_win_i) |=> (irq_req_o && rst_src_o != CS_POWERON));

    // R1: no interrupt without an active flag
    a_r1_irq_needs_flag: assert property (@(posedge clk) disable iff (!por_n)
        !dev_active |=> !irq_req_o);

endmodule

// File: tb/dbgrst_guard_test.sv
module dbgrst_guard_test;

    localparam int L = 2;

    logic clk = 1'b0;
    logic por_n = 1'b0;
    logic strap = 1'b0;
    logic [2:0] opm = 3'd0;
    logic mwr = 0, mdev = 0, swr = 0, sdev = 0;
    logic f_ovf = 0, f_win = 0, f_int = 0, f_st = 0, f_v1 = 0, f_uv = 0, f_fs = 0;
    logic rst_o, fs_o, irq_o;
    logic [2:0] src_o;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    bit done = 0;
    string cur = "R1";

    // reference model state
    int ms;
    int mcnt;
    bit mrst, mfs, mirq;
    int msrc;

    always #2.5 clk = ~clk;

    dbgrst_guard #(.RST_LEN(L)) uut (
        .clk(clk), .por_n(por_n), .strap_i(strap), .opmode_i(opm),
        .mode_wr_i(mwr), .mode_dev_i(mdev), .spec_wr_i(swr), .spec_dev_i(sdev),
        .wd_ovf_i(f_ovf), .wd_win_i(f_win), .int_to_i(f_int), .start_to_i(f_st),
        .v1_low_i(f_v1), .uv_clamp_i(f_uv), .fs_cause_i(f_fs),
        .rst_req_o(rst_o), .failsafe_req_o(fs_o), .irq_req_o(irq_o), .rst_src_o(src_o)
    );

    task automatic model_reset();
        ms = 0; mcnt = 0; mrst = 0; mfs = 0; mirq = 0; msrc = 0;
    endtask

    task automatic model_step();
        bit dev, lp, on, ol, trig;
        if (!por_n) begin
            model_reset();
            return;
        end
        dev = (ms == 2);
        lp  = (opm == 3) || (opm == 4);
        on  = f_ovf && !lp;
        ol  = f_ovf && lp;
        trig = f_v1 || ol || (!dev && (on || f_win || f_int || f_st));
        if (f_uv) msrc = 7;
        else if (f_v1) msrc = 5;
        else if (ol) msrc = 6;
        else if (on) msrc = 1;
        else if (f_win) msrc = 2;
        else if (f_int && !dev) msrc = 3;
        else if (f_st && !dev) msrc = 4;
        mirq = dev && (on || f_win);
        mfs  = f_uv || (f_fs && !dev);
        if (trig) begin
            mrst = 1; mcnt = L - 1;
        end else if (mcnt != 0) begin
            mcnt--; mrst = 1;
        end else begin
            mrst = 0;
        end
        case (ms)
            0: ms = strap ? 2 : 1;
            1: if (swr && sdev && opm == 0) ms = 2;
            2: if (mwr && !mdev) ms = 3;
            default: ms = 3;
        endcase
    endtask

    task automatic compare();
        logic [5:0] act, exp;
        act = {rst_o, fs_o, irq_o, src_o};
        exp = {mrst, mfs, mirq, 3'(msrc)};
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: {rst,fs,irq,src} actual=%b expected=%b at cycle %0d",
                     cur, act, exp, cycles);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare();
    endtask

    task automatic clear_strobes();
        mwr = 0; mdev = 0; swr = 0; sdev = 0;
        f_ovf = 0; f_win = 0; f_int = 0; f_st = 0; f_v1 = 0; f_uv = 0; f_fs = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic power_on(input bit s);
        @(negedge clk);
        por_n = 0;
        strap = s;
        clear_strobes();
        model_reset();
        cur = "R1";
        idle(3);
        por_n = 1;
        tick();
        strap = 0;
        idle(2);
    endtask

    // fault bundle bits: 0 ovf,1 win,2 int,3 start,4 v1,5 uv,6 fs
    task automatic fire(input logic [6:0] f);
        {f_fs, f_uv, f_v1, f_st, f_int, f_win, f_ovf} = f;
        tick();
        clear_strobes();
        idle(L + 2);
    endtask

    task automatic mode_write(input bit b);
        mwr = 1; mdev = b;
        tick();
        clear_strobes();
    endtask

    task automatic spec_write(input bit b);
        swr = 1; sdev = b;
        tick();
        clear_strobes();
    endtask

    always @(posedge clk) cycles++;

    initial begin
        wait (cycles > 20000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        model_reset();
        power_on(0);
        opm = 3'd2;
        cur = "R6"; fire(7'b0000001); fire(7'b0000010); fire(7'b0000100); fire(7'b0001000);
        cur = "R12";
        f_win = 1; tick(); clear_strobes(); tick();
        f_win = 1; tick(); clear_strobes(); idle(5);
        cur = "R11"; fire(7'b0001110); fire(7'b0010001); fire(7'b0110000);
        cur = "R8"; fire(7'b1000000);
        cur = "R3"; spec_write(1); fire(7'b0000010);
        opm = 3'd0; spec_write(0); fire(7'b0000010);
        spec_write(1); fire(7'b0000010);
        cur = "R7"; fire(7'b0000001); fire(7'b0000010);
        cur = "R6"; fire(7'b0000100); fire(7'b0001000); fire(7'b0001100);
        cur = "R8"; fire(7'b1000000); fire(7'b0100000);
        cur = "R9"; opm = 3'd0; fire(7'b0010000);
        cur = "R10"; opm = 3'd3; fire(7'b0000001); opm = 3'd4; fire(7'b0000011);
        cur = "R11"; opm = 3'd2; fire(7'b0001111);
        cur = "R4"; mode_write(1); fire(7'b0000010);
        mode_write(0); fire(7'b0000010);
        cur = "R5"; opm = 3'd0; spec_write(1); fire(7'b0000010);
        strap = 1; idle(2); strap = 0; fire(7'b0000010);
        cur = "R2"; power_on(1); opm = 3'd2; fire(7'b0000010);
        cur = "R4"; mode_write(0); fire(7'b0000010);
        cur = "R5"; opm = 3'd0; spec_write(1); fire(7'b0000010);
        cur = "R3"; power_on(0); opm = 3'd0; spec_write(1); fire(7'b0000010);
        cur = "R1"; power_on(0); idle(2);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule